// File: doc/BRIEF.md
# Stereo Serial Audio Port, Frame Master

This block drives the master side of a stereo serial audio link. It generates the bit clock and the frame sync, sends a 16-bit left and right playback sample on the serial output, and collects a 16-bit left and right capture sample from the serial input. Every frame has 64 bit periods. A two-bit layout select picks one of three frame layouts. In the enhanced layout, a status word follows the samples. In the plain 64-bit layout, the last two 16-bit slots are silent. In the compact layout, the bit clock stops for the second half of the frame.

The bit rate comes only from a strobe input, `bit_en`. Each strobe advances the serial clock by one half period. The serial pins are registered and change only in the cycle after a strobe. If the strobe spacing changes because the sample rate changes, the clock high and low phases get longer but never shorter. The port keeps framing without a pause. The layout select and all playback inputs are taken once per frame, at the frame boundary. At that same boundary the block presents the samples captured during the frame that just ended, together with a one-cycle `frame_done` pulse.

Top module: `sap_port`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe: `sclk` is low, `fsync` is high, `sdout` is low, `frame_done` is low, and both capture outputs are zero. The port starts in bit period 63.
- R2: Each `bit_en` strobe toggles the internal clock phase. `sclk`, `fsync` and `sdout` change only in the cycle after a strobe. In every bit period, `sclk` goes high on the first strobe (unless the clock is gated) and low on the second.
- R3: `fsync` is high during bit period 63 of every frame, which is the period just before the first data bit. It is low in periods 0 to 62.
- R4: `sdout` moves to a new bit on the falling-phase strobe. Periods 0 to 15 carry the playback left sample, bit 15 first. Periods 16 to 31 carry the playback right sample, bit 15 first.
- R5: `sdin` is sampled on the rising-phase strobe of periods 0 to 31. Periods 0 to 15 fill capture left, bit 15 first. Periods 16 to 31 fill capture right, bit 15 first. Levels on `sdin` in periods 32 to 63 have no effect on the captured pair.
- R6: `frame_done` pulses high for exactly one cycle after the strobe that starts period 0, and `rx_left`/`rx_right` then hold the pair captured in the frame just ended. There is no pulse at the first boundary after a reset.
- R7: Layout 00 (enhanced) gives 64 clock periods. On `sdout`, period 32 carries the interrupt flag, period 40 capture-enable, period 41 playback-enable, and period 42 the OR of the two overrange inputs. All other periods from 32 to 63 are low.
- R8: Layout 01 gives 64 clock periods, with `sdout` low in periods 32 to 63.
- R9: Layout 10 clocks periods 0 to 31 and holds `sclk` low with no edge in periods 32 to 63. `sdout` is low in those periods.
- R10: Select value 11 behaves exactly like layout 01.
- R11: The layout select and the playback inputs are taken only at the frame boundary. A change in the middle of a frame has no effect on the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Half-bit strobe that sets the serial rate |
| fmt_sel | input | 2 | Frame layout select: 00 enhanced, 01 plain 64-bit, 10 compact, 11 same as 01 |
| tx_left | input | 16 | Playback left sample |
| tx_right | input | 16 | Playback right sample |
| irq_flag | input | 1 | Interrupt flag for the status word |
| cap_en | input | 1 | Capture-enable flag for the status word |
| play_en | input | 1 | Playback-enable flag for the status word |
| ovr_left | input | 1 | Left overrange condition |
| ovr_right | input | 1 | Right overrange condition |
| sdin | input | 1 | Serial capture data |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync, high for the last bit period of a frame |
| sdout | output | 1 | Serial playback data |
| rx_left | output | 16 | Captured left sample |
| rx_right | output | 16 | Captured right sample |
| frame_done | output | 1 | One-cycle pulse at each frame boundary when a new captured pair is presented |

## Verification
The hardest case to reach is a layout switch, or a sample-rate change, that arrives while a frame is in progress. The stimulus must show that the frame in flight finishes in its old layout, with the old data, and with no short clock phase. To reach it, the bench inverts the layout select, the playback samples and the flags at bit period 20 of every frame. It also changes the strobe spacing from one bit period to the next. It then checks that each bit still follows the values latched at the boundary, and that no serial pin moves between strobes. Captured data is checked one boundary later, with deliberately opposite levels driven on `sdin` during the ignored half of the frame.

// File: rtl/sap_pkg.sv
package sap_pkg;

    typedef enum logic [1:0] {
        FMT_ENH = 2'b00,
        FMT_64  = 2'b01,
        FMT_32  = 2'b10
    } sap_fmt_e;

    // status bit distances from the first trailer bit
    localparam int ST_IRQ_OFS = 0;
    localparam int ST_CEN_OFS = 8;
    localparam int ST_PEN_OFS = 9;
    localparam int ST_OVR_OFS = 10;

    function automatic sap_fmt_e sap_norm_fmt(input logic [1:0] sel);
        case (sel)
            2'b00:   return FMT_ENH;
            2'b10:   return FMT_32;
            default: return FMT_64;
        endcase
    endfunction

endpackage

// File: rtl/sap_timing.sv
module sap_timing
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    localparam int FRAME_BITS = 4 * SAMPLE_W,
    localparam int CNT_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  sap_fmt_e         fmt_new_i,
    output logic             sclk_o,
    output logic             fsync_o,
    output logic             fall_o,
    output logic             bnd_o,
    output logic             cap_o,
    output logic [CNT_W-1:0] bitn_o,
    output sap_fmt_e         fmt_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] HALF_IDX = CNT_W'(2 * SAMPLE_W);

    typedef struct packed {
        logic             ph;
        logic             sclk;
        logic             fsync;
        logic [CNT_W-1:0] bitn;
        sap_fmt_e         fmt;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.ph = ~st_q.ph;
            if (!st_q.ph) begin
                // rising phase: stay low in the clockless half of compact layout
                st_d.sclk = !(st_q.fmt == FMT_32 && st_q.bitn >= HALF_IDX);
            end else begin
                st_d.sclk  = 1'b0;
                st_d.bitn  = (st_q.bitn == LAST_IDX) ? '0 : st_q.bitn + 1'b1;
                st_d.fsync = (st_d.bitn == LAST_IDX);
                if (st_q.bitn == LAST_IDX) begin
                    st_d.fmt = fmt_new_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: 1'b0, sclk: 1'b0, fsync: 1'b1, bitn: LAST_IDX, fmt: FMT_ENH};
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o  = st_q.sclk;
    assign fsync_o = st_q.fsync;
    assign fall_o  = tick_i && st_q.ph;
    assign bnd_o   = tick_i && st_q.ph && (st_q.bitn == LAST_IDX);
    assign cap_o   = tick_i && !st_q.ph && (st_q.bitn < HALF_IDX);
    assign bitn_o  = st_q.bitn;
    assign fmt_o   = st_q.fmt;

    assert_sclk_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_o) |-> $past(tick_i));

    assert_fsync_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsync_o) |-> $past(tick_i));

    assert_compact_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_o == FMT_32 && bitn_o >= HALF_IDX) |-> !sclk_o);

    assert_fmt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_o) |-> $past(bnd_o));

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    localparam int TRAIL_W = 2 * SAMPLE_W,
    localparam int WORD_W = 4 * SAMPLE_W,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_i,
    input  logic                bnd_i,
    input  sap_fmt_e            fmt_new_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                irq_i,
    input  logic                cen_i,
    input  logic                pen_i,
    input  logic                ovl_i,
    input  logic                ovr_i,
    input  logic [CNT_W-1:0]    bitn_i,
    input  sap_fmt_e            fmt_i,
    output logic                sdout_o
);
    localparam logic [CNT_W-1:0] HALF_IDX = CNT_W'(TRAIL_W);
    localparam logic [CNT_W-1:0] QUIET_IDX = CNT_W'(TRAIL_W + ST_OVR_OFS + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              sdout;
    } tx_state_t;

    tx_state_t          st_d, st_q;
    logic [TRAIL_W-1:0] trail;
    logic [WORD_W-1:0]  fresh;

    always_comb begin
        trail = '0;
        if (fmt_new_i == FMT_ENH) begin
            trail[TRAIL_W-1-ST_IRQ_OFS] = irq_i;
            trail[TRAIL_W-1-ST_CEN_OFS] = cen_i;
            trail[TRAIL_W-1-ST_PEN_OFS] = pen_i;
            trail[TRAIL_W-1-ST_OVR_OFS] = ovl_i | ovr_i;
        end
        fresh = {left_i, right_i, trail};

        st_d = st_q;
        if (bnd_i) begin
            st_d.sdout = fresh[WORD_W-1];
            st_d.word  = fresh << 1;
        end else if (fall_i) begin
            st_d.sdout = st_q.word[WORD_W-1];
            st_d.word  = st_q.word << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdout_o = st_q.sdout;

    assert_silent_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i != FMT_ENH && bitn_i >= HALF_IDX) |-> !sdout_o);

    assert_status_tail_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i == FMT_ENH && bitn_i >= QUIET_IDX) |-> !sdout_o);

endmodule

// File: rtl/sap_rx.sv
module sap_rx #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_i,
    input  logic                bnd_i,
    input  logic                sdin_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                done_o
);
    typedef struct packed {
        logic [2*SAMPLE_W-1:0] sr;
        logic [SAMPLE_W-1:0]   left;
        logic [SAMPLE_W-1:0]   right;
        logic                  started;
        logic                  done;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (cap_i) begin
            st_d.sr = {st_q.sr[2*SAMPLE_W-2:0], sdin_i};
        end
        if (bnd_i) begin
            st_d.started = 1'b1;
            if (st_q.started) begin
                st_d.left  = st_q.sr[2*SAMPLE_W-1:SAMPLE_W];
                st_d.right = st_q.sr[SAMPLE_W-1:0];
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign left_o  = st_q.left;
    assign right_o = st_q.right;
    assign done_o  = st_q.done;

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    localparam int CNT_W = $clog2(4 * SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic [1:0]          fmt_sel,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                irq_flag,
    input  logic                cap_en,
    input  logic                play_en,
    input  logic                ovr_left,
    input  logic                ovr_right,
    input  logic                sdin,
    output logic                sclk,
    output logic                fsync,
    output logic                sdout,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                frame_done
);
    sap_fmt_e         fmt_new, fmt_cur;
    logic             fall_s, bnd_s, cap_s;
    logic [CNT_W-1:0] bitn;

    assign fmt_new = sap_norm_fmt(fmt_sel);

    sap_timing #(.SAMPLE_W(SAMPLE_W)) timing_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (bit_en),
        .fmt_new_i(fmt_new),
        .sclk_o   (sclk),
        .fsync_o  (fsync),
        .fall_o   (fall_s),
        .bnd_o    (bnd_s),
        .cap_o    (cap_s),
        .bitn_o   (bitn),
        .fmt_o    (fmt_cur)
    );

    sap_tx #(.SAMPLE_W(SAMPLE_W)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_i   (fall_s),
        .bnd_i    (bnd_s),
        .fmt_new_i(fmt_new),
        .left_i   (tx_left),
        .right_i  (tx_right),
        .irq_i    (irq_flag),
        .cen_i    (cap_en),
        .pen_i    (play_en),
        .ovl_i    (ovr_left),
        .ovr_i    (ovr_right),
        .bitn_i   (bitn),
        .fmt_i    (fmt_cur),
        .sdout_o  (sdout)
    );

    sap_rx #(.SAMPLE_W(SAMPLE_W)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_s),
        .bnd_i  (bnd_s),
        .sdin_i (sdin),
        .left_o (rx_left),
        .right_o(rx_right),
        .done_o (frame_done)
    );

endmodule

// File: tb/sap_port_tb_top.sv
`timescale 1ns/1ps
module sap_port_tb_top;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [15:0] l;
        logic [15:0] r;
        logic [15:0] il;
        logic [15:0] ir;
        logic        irq;
        logic        cen;
        logic        pen;
        logic        ovl;
        logic        ovr;
        logic [3:0]  gap;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 16'hA5C3, 16'h3C5A, 16'h1234, 16'hFEDC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1},
        '{2'b01, 16'h8001, 16'h7FFE, 16'h0F0F, 16'hF0F0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd2},
        '{2'b10, 16'hFFFF, 16'h0000, 16'hAAAA, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},
        '{2'b00, 16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},
        '{2'b11, 16'h1357, 16'h2468, 16'hC3C3, 16'h3C3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd1},
        '{2'b10, 16'h4321, 16'h8765, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
        '{2'b00, 16'hDEAD, 16'hBEEF, 16'h0001, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2},
        '{2'b01, 16'h0001, 16'h8000, 16'h7777, 16'h8888, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [15:0] tx_left = '0, tx_right = '0;
    logic        irq_flag = 1'b0, cap_en = 1'b0, play_en = 1'b0;
    logic        ovr_left = 1'b0, ovr_right = 1'b0, sdin = 1'b0;
    logic        sclk, fsync, sdout, frame_done;
    logic [15:0] rx_left, rx_right;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  finished = 0;
    logic fd_at_tick;

    always #2 clk = ~clk;

    sap_port #(.SAMPLE_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fmt_sel(fmt_sel),
        .tx_left(tx_left), .tx_right(tx_right), .irq_flag(irq_flag),
        .cap_en(cap_en), .play_en(play_en), .ovr_left(ovr_left),
        .ovr_right(ovr_right), .sdin(sdin), .sclk(sclk), .fsync(fsync),
        .sdout(sdout), .rx_left(rx_left), .rx_right(rx_right),
        .frame_done(frame_done)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one strobe, then gap idle cycles during which the pins must hold
    task automatic tick(int gap);
        logic s, f;
        bit hold_ok, done_ok;
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        fd_at_tick = frame_done;
        s = sclk;
        f = fsync;
        hold_ok = 1;
        done_ok = 1;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            if (sclk !== s || fsync !== f) hold_ok = 0;
            if (frame_done !== 1'b0) done_ok = 0;
        end
        chk("R2 pins hold between strobes", 32'(hold_ok), 32'd1);
        chk("R6 frame_done lasts one cycle", 32'(done_ok), 32'd1);
    endtask

    task automatic check_reset_state();
        chk("R1 sclk", 32'(sclk), 32'd0);
        chk("R1 fsync", 32'(fsync), 32'd1);
        chk("R1 sdout", 32'(sdout), 32'd0);
        chk("R1 frame_done", 32'(frame_done), 32'd0);
        chk("R1 rx pair", {rx_left, rx_right}, 32'd0);
    endtask

    // strobe that starts period 0, checks the pair of the frame that ended
    task automatic close_frame(bit had_prev, logic [15:0] il, logic [15:0] ir);
        tick(1);
        chk("R6 frame_done at boundary", 32'(fd_at_tick), 32'(had_prev));
        if (had_prev) begin
            chk("R5 captured left", 32'(rx_left), 32'(il));
            chk("R5 captured right", 32'(rx_right), 32'(ir));
        end
    endtask

    task automatic run_frame(vec_t v, bit had_prev, logic [15:0] pil, logic [15:0] pir);
        logic [1:0]  fe;
        logic [31:0] trail;
        logic [63:0] ew;
        logic        exp_sclk;
        fmt_sel   = v.fmt;
        tx_left   = v.l;
        tx_right  = v.r;
        irq_flag  = v.irq;
        cap_en    = v.cen;
        play_en   = v.pen;
        ovr_left  = v.ovl;
        ovr_right = v.ovr;
        fe = (v.fmt == 2'b11) ? 2'b01 : v.fmt;   // R10
        trail = '0;
        if (fe == 2'b00) begin
            trail[31] = v.irq;
            trail[23] = v.cen;
            trail[22] = v.pen;
            trail[21] = v.ovl | v.ovr;
        end
        ew = {v.l, v.r, trail};
        close_frame(had_prev, pil, pir);
        for (int b = 0; b < 64; b++) begin
            if (b == 20) begin
                // R11: mid-frame changes must not reach this frame
                fmt_sel   = ~v.fmt;
                tx_left   = ~v.l;
                tx_right  = ~v.r;
                irq_flag  = ~v.irq;
                cap_en    = ~v.cen;
                play_en   = ~v.pen;
                ovr_left  = ~v.ovl;
                ovr_right = ~v.ovr;
            end
            if (b < 32)
                chk("R4 sample bit on sdout", 32'(sdout), 32'(ew[63-b]));
            else if (fe == 2'b00)
                chk("R7 status trailer bit", 32'(sdout), 32'(ew[63-b]));
            else if (fe == 2'b01)
                chk("R8 silent slots", 32'(sdout), 32'd0);
            else
                chk("R9 compact tail sdout", 32'(sdout), 32'd0);
            chk("R3 fsync level", 32'(fsync), 32'(b == 63));
            chk("R2 sclk low after falling strobe", 32'(sclk), 32'd0);
            if (b < 16)      sdin = v.il[15-b];
            else if (b < 32) sdin = v.ir[31-b];
            else             sdin = b[0];   // R5: ignored half
            tick(int'(v.gap) + (b % 3));
            exp_sclk = !(fe == 2'b10 && b >= 32);
            if (exp_sclk)
                chk("R2 sclk high after rising strobe", 32'(sclk), 32'd1);
            else
                chk("R9 compact tail sclk held low", 32'(sclk), 32'd0);
            if (b < 63) tick(int'(v.gap));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state();
        tick(1);
        chk("R2 first rising strobe", 32'(sclk), 32'd1);
        for (int k = 0; k < NVEC; k++) begin
            run_frame(VECS[k], k > 0,
                      (k > 0) ? VECS[k-1].il : 16'h0,
                      (k > 0) ? VECS[k-1].ir : 16'h0);
        end
        close_frame(1'b1, VECS[NVEC-1].il, VECS[NVEC-1].ir);

        // directed: reset in the middle of a frame
        for (int i = 0; i < 10; i++) tick(2);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        tick(1);
        close_frame(1'b0, 16'h0, 16'h0);
        chk("R4 first bit after reset", 32'(sdout), 32'(VECS[NVEC-1].l[15] ^ 1'b1));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule